// File: doc/BRIEF.md
# Integer Execute Unit with Trap and Overflow Reporting

This block is the integer execute stage of a 32-bit load/store pipeline. In a single combinational pass it takes an operation code, two source operands `s` and `t`, and a 5-bit immediate shift amount. It returns a result word, an exception cause, and a write-discard flag that tells the write-back stage to leave the destination register untouched. It covers fixed and register-driven shifts, and add and subtract in checked and wrapping forms. It also covers the four bitwise operations, signed and unsigned set-less-than, the zero/nonzero conditional moves, transfers to and from a HI/LO register pair, and six conditional traps.

The HI/LO pair is the only state in the block. A write to either register is presented as a strobe in the same cycle as the operation and lands on the next rising clock edge. The pipeline issues one operation per cycle. The upper stage decides what to do with a raised cause; this block only reports it.

Top module: `int_exec_unit`

## Requirements
- R1: Codes 0, 1 and 2 shift `t` by `shamt_i`: left with zero fill, right with zero fill, and right with sign fill. The result uses cause 0 (none) and the discard flag is low.
- R2: Codes 3, 4 and 5 perform the same three shifts, but the amount comes from the low 5 bits of `s`. The upper bits of `s` have no effect.
- R3: Code 6 (checked add) and code 8 (checked subtract `s-t`) give cause 1 (overflow) and raise discard on signed overflow. Code 7 (add) and code 9 (subtract) wrap modulo 2^32 and always give cause 0.
- R4: Codes 10, 11, 12 and 13 return `s AND t`, `s OR t`, `s XOR t` and `NOT(s OR t)`.
- R5: Code 14 returns 1 when `s < t` as signed numbers and 0 otherwise. Code 15 makes the same comparison as unsigned numbers.
- R6: Code 16 (move-if-zero) and code 17 (move-if-nonzero) return `s`. Discard is raised when the test on `t` fails. The cause is 0.
- R7: Codes 18 and 19 return HI and LO. Code 20 raises `hi_we_o` and code 21 raises `lo_we_o`; both return 0, and at the next clock edge `s` is written into that register only. Reset clears both registers and wins over a write in the same cycle.
- R8: Codes 22 to 27 raise cause 2 (trap) and discard when their condition on `s` versus `t` holds. The conditions are, in order: equal, not equal, signed greater-or-equal, unsigned greater-or-equal, signed less-than, and unsigned less-than. Otherwise the cause is 0. Every trap returns 0.
- R9: Codes 28 to 31 give cause 3 (illegal), result 0, discard high and no HI/LO strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the HI/LO pair |
| rst | input | 1 | Synchronous active-high reset of HI/LO |
| op_i | input | 5 | Operation code |
| s_i | input | 32 | First source operand |
| t_i | input | 32 | Second source operand |
| shamt_i | input | 5 | Immediate shift amount |
| result_o | output | 32 | Result word |
| cause_o | output | 2 | 0 none, 1 overflow, 2 trap, 3 illegal |
| discard_o | output | 1 | Suppress the destination write |
| hi_we_o | output | 1 | HI write strobe |
| lo_we_o | output | 1 | LO write strobe |

## Verification
Two functions can land in the same cycle: a HI or LO write strobe and the synchronous reset. The bench issues a move-to-HI with a nonzero operand while reset is held high. In the cycle after, it reads HI back through code 18 and expects 0. A second collision occurs inside one operation: an overflow or trap cause together with the discard flag. This is judged on every clock by the reference model, which computes cause and discard separately from the operands.

// File: rtl/alu_exec_pkg.sv
package alu_exec_pkg;

    localparam int OPW = 5;

    typedef enum logic [OPW-1:0] {
        OP_SLL_I   = 5'd0,
        OP_SRL_I   = 5'd1,
        OP_SRA_I   = 5'd2,
        OP_SLL_V   = 5'd3,
        OP_SRL_V   = 5'd4,
        OP_SRA_V   = 5'd5,
        OP_ADD_CHK = 5'd6,
        OP_ADD_WRP = 5'd7,
        OP_SUB_CHK = 5'd8,
        OP_SUB_WRP = 5'd9,
        OP_AND     = 5'd10,
        OP_OR      = 5'd11,
        OP_XOR     = 5'd12,
        OP_NOR     = 5'd13,
        OP_LT_S    = 5'd14,
        OP_LT_U    = 5'd15,
        OP_MOV_Z   = 5'd16,
        OP_MOV_NZ  = 5'd17,
        OP_RD_HI   = 5'd18,
        OP_RD_LO   = 5'd19,
        OP_WR_HI   = 5'd20,
        OP_WR_LO   = 5'd21,
        OP_TR_EQ   = 5'd22,
        OP_TR_NE   = 5'd23,
        OP_TR_GE   = 5'd24,
        OP_TR_GEU  = 5'd25,
        OP_TR_LT   = 5'd26,
        OP_TR_LTU  = 5'd27
    } alu_op_e;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'd0,
        CAUSE_OVF     = 2'd1,
        CAUSE_TRAP    = 2'd2,
        CAUSE_ILLEGAL = 2'd3
    } cause_e;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_RLOG  = 2'd1,
        SH_RARI  = 2'd2
    } shift_kind_e;

    function automatic logic is_var_shift(input logic [OPW-1:0] op);
        return (op == OP_SLL_V) || (op == OP_SRL_V) || (op == OP_SRA_V);
    endfunction

    function automatic shift_kind_e shift_kind_of(input logic [OPW-1:0] op);
        case (op)
            OP_SRL_I, OP_SRL_V: return SH_RLOG;
            OP_SRA_I, OP_SRA_V: return SH_RARI;
            default:            return SH_LEFT;
        endcase
    endfunction

endpackage

// File: rtl/alu_shift.sv
module alu_shift
    import alu_exec_pkg::*;
#(
    parameter int W = 32,
    localparam int SHW = $clog2(W)
) (
    input  logic [W-1:0]   val,
    input  logic [SHW-1:0] amt,
    input  shift_kind_e    kind,
    output logic [W-1:0]   res
);
    localparam logic [W-1:0] ONES = {W{1'b1}};

    logic [SHW:0][W-1:0] st;
    logic left;
    logic fill;

    assign left  = (kind == SH_LEFT);
    assign fill  = (kind == SH_RARI) && val[W-1];
    assign st[0] = val;

    // Logarithmic barrel: stage k moves by 2^k when amt[k] is set
    for (genvar k = 0; k < SHW; k++) begin : g_stage
        localparam int S = 1 << k;
        logic [W-1:0] mask;
        assign mask    = fill ? ~(ONES >> S) : '0;
        assign st[k+1] = !amt[k] ? st[k]
                       : (left ? (st[k] << S) : ((st[k] >> S) | mask));
    end

    assign res = st[SHW];
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         ovf,
    output logic         lt_s,
    output logic         lt_u
);
    logic [W-1:0] bx;
    logic         cout;

    assign bx          = sub ? ~b : b;
    assign {cout, sum} = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, sub};
    assign ovf         = (a[W-1] == bx[W-1]) && (sum[W-1] != a[W-1]);
    // Only meaningful with sub=1: sign of the true difference, and borrow
    assign lt_s        = sum[W-1] ^ ovf;
    assign lt_u        = ~cout;
endmodule

// File: rtl/alu_trap_cond.sv
module alu_trap_cond
    import alu_exec_pkg::*;
(
    input  logic [OPW-1:0] op,
    input  logic           eq,
    input  logic           lt_s,
    input  logic           lt_u,
    output logic           is_trap,
    output logic           fire
);
    always_comb begin
        is_trap = 1'b1;
        fire    = 1'b0;
        case (op)
            OP_TR_EQ:  fire = eq;
            OP_TR_NE:  fire = !eq;
            OP_TR_GE:  fire = !lt_s;
            OP_TR_GEU: fire = !lt_u;
            OP_TR_LT:  fire = lt_s;
            OP_TR_LTU: fire = lt_u;
            default:   is_trap = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_hilo.sv
module alu_hilo #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hi_we,
    input  logic         lo_we,
    input  logic [W-1:0] d,
    output logic [W-1:0] hi,
    output logic [W-1:0] lo
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hi <= '0;
            lo <= '0;
        end else begin
            if (hi_we) hi <= d;
            if (lo_we) lo <= d;
        end
    end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
    import alu_exec_pkg::*;
#(
    parameter int W = 32,
    localparam int SHW = $clog2(W)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [OPW-1:0] op_i,
    input  logic [W-1:0]   s_i,
    input  logic [W-1:0]   t_i,
    input  logic [SHW-1:0] shamt_i,
    output logic [W-1:0]   result_o,
    output logic [1:0]     cause_o,
    output logic           discard_o,
    output logic           hi_we_o,
    output logic           lo_we_o
);
    logic [SHW-1:0] sh_amt;
    shift_kind_e    sh_kind;
    logic [W-1:0]   sh_res;
    logic           as_sub;
    logic [W-1:0]   as_sum;
    logic           as_ovf, as_lt_s, as_lt_u;
    logic           tr_is, tr_fire;
    logic [W-1:0]   hi_q, lo_q;
    logic           mv_fail;
    cause_e         cause;

    assign sh_amt  = is_var_shift(op_i) ? s_i[SHW-1:0] : shamt_i;
    assign sh_kind = shift_kind_of(op_i);
    assign as_sub  = !((op_i == OP_ADD_CHK) || (op_i == OP_ADD_WRP));

    alu_shift #(.W(W)) u_shift (
        .val (t_i),
        .amt (sh_amt),
        .kind(sh_kind),
        .res (sh_res)
    );

    alu_addsub #(.W(W)) u_addsub (
        .a   (s_i),
        .b   (t_i),
        .sub (as_sub),
        .sum (as_sum),
        .ovf (as_ovf),
        .lt_s(as_lt_s),
        .lt_u(as_lt_u)
    );

    alu_trap_cond u_trap (
        .op     (op_i),
        .eq     (s_i == t_i),
        .lt_s   (as_lt_s),
        .lt_u   (as_lt_u),
        .is_trap(tr_is),
        .fire   (tr_fire)
    );

    alu_hilo #(.W(W)) u_hilo (
        .clk  (clk),
        .rst  (rst),
        .hi_we(hi_we_o),
        .lo_we(lo_we_o),
        .d    (s_i),
        .hi   (hi_q),
        .lo   (lo_q)
    );

    always_comb begin
        result_o = '0;
        cause    = CAUSE_NONE;
        mv_fail  = 1'b0;
        hi_we_o  = 1'b0;
        lo_we_o  = 1'b0;
        case (op_i)
            OP_SLL_I, OP_SRL_I, OP_SRA_I,
            OP_SLL_V, OP_SRL_V, OP_SRA_V: result_o = sh_res;
            OP_ADD_CHK, OP_SUB_CHK: begin
                result_o = as_sum;
                if (as_ovf) cause = CAUSE_OVF;
            end
            OP_ADD_WRP, OP_SUB_WRP: result_o = as_sum;
            OP_AND:    result_o = s_i & t_i;
            OP_OR:     result_o = s_i | t_i;
            OP_XOR:    result_o = s_i ^ t_i;
            OP_NOR:    result_o = ~(s_i | t_i);
            OP_LT_S:   result_o = {{(W-1){1'b0}}, as_lt_s};
            OP_LT_U:   result_o = {{(W-1){1'b0}}, as_lt_u};
            OP_MOV_Z: begin
                result_o = s_i;
                mv_fail  = (t_i != '0);
            end
            OP_MOV_NZ: begin
                result_o = s_i;
                mv_fail  = (t_i == '0);
            end
            OP_RD_HI:  result_o = hi_q;
            OP_RD_LO:  result_o = lo_q;
            OP_WR_HI:  hi_we_o  = 1'b1;
            OP_WR_LO:  lo_we_o  = 1'b1;
            default: begin
                if (tr_is) begin
                    if (tr_fire) cause = CAUSE_TRAP;
                end else begin
                    cause = CAUSE_ILLEGAL;
                end
            end
        endcase
    end

    assign cause_o   = cause;
    assign discard_o = mv_fail || (cause != CAUSE_NONE);
endmodule

// File: rtl/int_exec_unit_chk.sv
module int_exec_unit_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic [4:0]   op_i,
    input logic [W-1:0] s_i,
    input logic [1:0]   cause_o,
    input logic         discard_o,
    input logic         hi_we_o,
    input logic         lo_we_o,
    input logic [W-1:0] hi_q,
    input logic [W-1:0] lo_q
);
    p_ovf_discards_r3: assert property (@(posedge clk) disable iff (rst)
        (cause_o == 2'd1) |-> discard_o);

    p_trap_discards_r8: assert property (@(posedge clk) disable iff (rst)
        (cause_o == 2'd2) |-> discard_o);

    p_trap_only_trap_ops_r8: assert property (@(posedge clk) disable iff (rst)
        (cause_o == 2'd2) |-> (op_i >= 5'd22 && op_i <= 5'd27));

    p_hi_written_r7: assert property (@(posedge clk) disable iff (rst)
        hi_we_o |=> (hi_q == $past(s_i)));

    p_lo_written_r7: assert property (@(posedge clk) disable iff (rst)
        lo_we_o |=> (lo_q == $past(s_i)));

    p_lo_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !lo_we_o |=> $stable(lo_q));

    p_strobe_single_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({hi_we_o, lo_we_o}));

    p_illegal_r9: assert property (@(posedge clk) disable iff (rst)
        (op_i >= 5'd28) |-> (cause_o == 2'd3 && discard_o && !hi_we_o && !lo_we_o));
endmodule

bind int_exec_unit int_exec_unit_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .op_i     (op_i),
    .s_i      (s_i),
    .cause_o  (cause_o),
    .discard_o(discard_o),
    .hi_we_o  (hi_we_o),
    .lo_we_o  (lo_we_o),
    .hi_q     (hi_q),
    .lo_q     (lo_q)
);

// File: tb/test_int_exec_unit.sv
module test_int_exec_unit;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  op_i = '0;
    logic [31:0] s_i = '0;
    logic [31:0] t_i = '0;
    logic [4:0]  shamt_i = '0;
    logic [31:0] result_o;
    logic [1:0]  cause_o;
    logic        discard_o, hi_we_o, lo_we_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] hi_m = '0;
    logic [31:0] lo_m = '0;

    always #(PERIOD/2) clk = ~clk;

    int_exec_unit i_int_exec_unit (
        .clk(clk), .rst(rst), .op_i(op_i), .s_i(s_i), .t_i(t_i),
        .shamt_i(shamt_i), .result_o(result_o), .cause_o(cause_o),
        .discard_o(discard_o), .hi_we_o(hi_we_o), .lo_we_o(lo_we_o)
    );

    // Behavioural reference built from the requirement text
    task automatic model(input int op, input logic [31:0] s, input logic [31:0] t,
                         input logic [4:0] sh, output logic [31:0] r, output int c,
                         output bit d, output bit hw, output bit lw);
        longint sum;
        longint si, ti;
        si = longint'($signed(s));
        ti = longint'($signed(t));
        r = 0; c = 0; d = 0; hw = 0; lw = 0;
        case (op)
            0: r = t << sh;
            1: r = t >> sh;
            2: r = 32'($signed(t) >>> sh);
            3: r = t << s[4:0];
            4: r = t >> s[4:0];
            5: r = 32'($signed(t) >>> s[4:0]);
            6, 7: begin
                sum = si + ti; r = s + t;
                if (op == 6 && (sum > 64'sd2147483647 || sum < -64'sd2147483648)) c = 1;
            end
            8, 9: begin
                sum = si - ti; r = s - t;
                if (op == 8 && (sum > 64'sd2147483647 || sum < -64'sd2147483648)) c = 1;
            end
            10: r = s & t;
            11: r = s | t;
            12: r = s ^ t;
            13: r = ~(s | t);
            14: r = (si < ti) ? 1 : 0;
            15: r = (s < t) ? 1 : 0;
            16: begin r = s; d = (t != 0); end
            17: begin r = s; d = (t == 0); end
            18: r = hi_m;
            19: r = lo_m;
            20: hw = 1;
            21: lw = 1;
            22: c = (s == t) ? 2 : 0;
            23: c = (s != t) ? 2 : 0;
            24: c = (si >= ti) ? 2 : 0;
            25: c = (s >= t) ? 2 : 0;
            26: c = (si < ti) ? 2 : 0;
            27: c = (s < t) ? 2 : 0;
            default: c = 3;
        endcase
        if (c != 0) d = 1;
    endtask

    task automatic step(input int op, input logic [31:0] s, input logic [31:0] t,
                        input logic [4:0] sh, input bit r_in, input string tag);
        logic [31:0] er;
        int ec;
        bit ed, ehw, elw;
        @(negedge clk);
        rst = r_in; op_i = 5'(op); s_i = s; t_i = t; shamt_i = sh;
        #(PERIOD/2 - 1);
        model(op, s, t, sh, er, ec, ed, ehw, elw);
        checks++;
        if (result_o !== er || cause_o !== 2'(ec) || discard_o !== ed ||
            hi_we_o !== ehw || lo_we_o !== elw) begin
            errors++;
            $display("FAIL %s op=%0d res=%h/%h cause=%0d/%0d disc=%0b/%0b hw=%0b/%0b lw=%0b/%0b",
                     tag, op, result_o, er, cause_o, ec, discard_o, ed, hi_we_o, ehw, lo_we_o, elw);
        end
        @(posedge clk);
        if (r_in) begin
            hi_m = '0; lo_m = '0;
        end else begin
            if (ehw) hi_m = s;
            if (elw) lo_m = s;
        end
    endtask

    initial begin
        #(PERIOD * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        step(10, 0, 0, 0, 1, "reset");
        step(10, 0, 0, 0, 1, "reset");
        // Reset state of HI/LO: R7
        step(18, 0, 0, 0, 0, "R7 reset HI");
        step(19, 0, 0, 0, 0, "R7 reset LO");
        // R1 immediate shifts
        step(0, 0, 32'h80000001, 3, 0, "R1 sll");
        step(1, 0, 32'h80000008, 3, 0, "R1 srl");
        step(2, 0, 32'h80000008, 3, 0, "R1 sra");
        step(2, 0, 32'h80000000, 31, 0, "R1 sra 31");
        step(1, 0, 32'h80000000, 31, 0, "R1 srl 31");
        step(0, 0, 32'h12345678, 0, 0, "R1 sll 0");
        // R2 variable shifts, upper bits of s ignored
        step(3, 3, 32'h80000001, 9, 0, "R2 sllv");
        step(4, 32'hFFFFFFE3, 32'h80000008, 0, 0, "R2 srlv high s");
        step(5, 3, 32'h80000008, 0, 0, "R2 srav");
        // R3 add/sub
        step(6, 24, 66, 0, 0, "R3 add");
        step(6, 32'h8FFFFFFF, 32'h90000000, 0, 0, "R3 add ovf");
        step(6, 32'h7FFFFFFF, 1, 0, 0, "R3 add ovf pos");
        step(7, 32'hFFFFFFFF, 1, 0, 0, "R3 addu wrap");
        step(8, 66, 24, 0, 0, "R3 sub");
        step(8, 32'h80000003, 4, 0, 0, "R3 sub ovf");
        step(8, 0, 32'h80000000, 0, 0, "R3 sub ovf min");
        step(9, 24, 66, 0, 0, "R3 subu wrap");
        // R4 bitwise
        step(10, 32'hA81, 32'h603, 0, 0, "R4 and");
        step(11, 32'hA81, 32'h603, 0, 0, "R4 or");
        step(12, 32'hA81, 32'h603, 0, 0, "R4 xor");
        step(13, 32'hA81, 32'h603, 0, 0, "R4 nor");
        // R5 set-less-than
        step(14, -32'sd31, 24, 0, 0, "R5 slt neg");
        step(14, 24, 24, 0, 0, "R5 slt equal");
        step(15, 24, 32, 0, 0, "R5 sltu");
        step(15, -32'sd31, 24, 0, 0, "R5 sltu big");
        // R6 conditional moves
        step(16, 22, 0, 0, 0, "R6 movz commit");
        step(16, 22, 5, 0, 0, "R6 movz discard");
        step(17, 22, 1, 0, 0, "R6 movn commit");
        step(17, 22, 0, 0, 0, "R6 movn discard");
        // R7 HI/LO transfers
        step(20, 42, 0, 0, 0, "R7 wr hi");
        step(21, 24, 0, 0, 0, "R7 wr lo");
        step(18, 0, 0, 0, 0, "R7 rd hi");
        step(19, 0, 0, 0, 0, "R7 rd lo");
        step(20, 43, 0, 0, 0, "R7 wr hi again");
        step(19, 0, 0, 0, 0, "R7 lo untouched");
        step(18, 0, 0, 0, 0, "R7 hi updated");
        // R7 reset collides with a HI write: reset wins
        step(20, 32'hDEAD, 0, 0, 1, "R7 wr hi under reset");
        step(18, 0, 0, 0, 0, "R7 hi cleared by reset");
        step(19, 0, 0, 0, 0, "R7 lo cleared by reset");
        // R8 traps, both outcomes
        step(22, 32'h12345678, 32'h12345678, 0, 0, "R8 teq fire");
        step(22, 32'h12345679, 32'h12345678, 0, 0, "R8 teq quiet");
        step(23, 32'h12345678, 32'h12345679, 0, 0, "R8 tne fire");
        step(23, 32'h12345678, 32'h12345678, 0, 0, "R8 tne quiet");
        step(24, 32'h12345679, 32'h12345678, 0, 0, "R8 tge fire");
        step(24, 32'hFFFFFFFF, 1, 0, 0, "R8 tge quiet");
        step(25, 32'hFFFFFFFF, 1, 0, 0, "R8 tgeu fire");
        step(25, 1, 2, 0, 0, "R8 tgeu quiet");
        step(26, 32'h80000000, 32'h7FFFFFFF, 0, 0, "R8 tlt fire");
        step(26, 5, 5, 0, 0, "R8 tlt quiet");
        step(27, 32'h12345678, 32'h12345679, 0, 0, "R8 tltu fire");
        step(27, 32'h80000000, 32'h7FFFFFFF, 0, 0, "R8 tltu quiet");
        // R9 illegal codes
        for (int k = 28; k < 32; k++) step(k, 7, 9, 1, 0, "R9 illegal");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule